// File: doc/BRIEF.md
# Flagged Byte Mailbox (Device Side)

A byte-wide mailbox through which a host hands a command to a device-side engine and collects the reply. The host sees two byte registers: a data register at offset 0 and a status/command register at offset 1 (reads return status, writes carry a command code). Frames in both directions are marked by in-band control bytes rather than by a length register.

The host opens a command with the open code, pushes command bytes one at a time under input-buffer handshaking, and closes with the end code. The block then answers with a framed stream under output-buffer handshaking: a flagged opening byte, the response bytes, and a flagged closing byte. A stub engine forms the response: a two-byte tag, a big-endian 32-bit total length, and an echo of the command bytes, or a fixed error reply when the command overflowed the buffer. The abort code returns the block to ready from any state.

Controller states: READY (waits for open), RECV (takes command bytes), EXEC (one cycle, engine latches the reply length), HEAD (presents the opening byte), BODY (presents reply bytes), TAIL (presents the closing byte). Transitions: READY->RECV on open; RECV->EXEC on end code; EXEC->HEAD always; HEAD->BODY on a data read; BODY->TAIL on the read of the last reply byte; TAIL->READY on a data read; any state->READY on abort.

Top module: `flagged_mailbox`

## Requirements
- R1: After reset the status register reads 0x10 (only ready, bit 4, set; bit 3 always reads 0) and the data register reads 0x00.
- R2: Writing 0x01 to offset 1 while ready clears ready and sets ready-for-data (bit 5): status reads 0x20.
- R3: A data write accepted while ready-for-data sets input-full (bit 1) from the next cycle; input-full clears IBF_LAT cycles later, and a data write made while input-full is set is dropped.
- R4: Writing 0x22 to offset 1 in any state returns the block to ready, with input-full, output-full and the flag cleared: status reads 0x10.
- R5: Writing 0x03 to offset 1 while ready-for-data ends the command; the reply is a byte 0x01 with flag F0 (bit 2) set, then the reply bytes with F0 clear, then 0x03 with F0 set.
- R6: Output-full (bit 0) is set while a reply byte waits; it stays set until offset 0 is read, the read clears it, and the next byte appears at least one cycle later.
- R7: The reply bytes are 0x00, 0xC4, then the total length 6+n as a big-endian 32-bit value, then the n command bytes in the order written.
- R8: A command of more than DEPTH bytes gets the 10-byte reply 00 C4 00 00 00 0A 00 00 00 ERR_CODE (default 0x15).
- R9: After the closing byte is read the block is ready again and a new open is accepted without an abort.
- R10: A data write while ready and an open while receiving have no effect on status or on the stored command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one cycle per byte |
| rd_en | input | 1 | Host read strobe; a read of offset 0 consumes a waiting byte |
| addr | input | 1 | Register select: 0 data, 1 status/command |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Read byte: status when addr is 1, presented reply byte when addr is 0 |

## Verification
Commands of length zero, one, five, exactly DEPTH and DEPTH+1 are sent back to back, each with a distinct byte seed, so that the length field, the echo order, the full-buffer edge and the overflow error reply are each told apart. Directed sequences then try a write made while input-full is still set, stray codes in the wrong state, and aborts both while receiving and in the middle of a reply, each followed by a normal command that shows no leftover state. Every reply byte is read together with the status before it, so the flag and output-full timing are checked on each byte.

// File: rtl/fm_pkg.sv
package fm_pkg;
    typedef enum logic [2:0] {
        ST_READY,
        ST_RECV,
        ST_EXEC,
        ST_HEAD,
        ST_BODY,
        ST_TAIL
    } fm_state_e;

    localparam logic [7:0] CODE_OPEN  = 8'h01;
    localparam logic [7:0] CODE_END   = 8'h03;
    localparam logic [7:0] CODE_ABORT = 8'h22;

    localparam int HDR_BYTES = 6;
    localparam int ERR_BYTES = 10;
endpackage

// File: rtl/fm_cmd_store.sv
module fm_cmd_store #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [7:0]    din,
    input  logic [AW-1:0] rd_sel,
    output logic [7:0]    rd_byte,
    output logic [CW-1:0] count,
    output logic          ovf
);
    logic [DEPTH-1:0][7:0] slots;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (push && count == CW'(g)) begin
                q <= din;
            end
        end
        assign slots[g] = q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
            ovf   <= 1'b0;
        end else if (push) begin
            if (count == CW'(DEPTH)) begin
                ovf <= 1'b1;
            end else begin
                count <= count + 1'b1;
            end
        end
    end

    assign rd_byte = (int'(rd_sel) < DEPTH) ? slots[rd_sel] : 8'h00;
endmodule

// File: rtl/fm_resp_engine.sv
module fm_resp_engine
    import fm_pkg::*;
#(
    parameter int         DEPTH    = 16,
    parameter logic [7:0] TAG_HI   = 8'h00,
    parameter logic [7:0] TAG_LO   = 8'hC4,
    parameter logic [7:0] ERR_CODE = 8'h15,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int IW = $clog2(DEPTH + HDR_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          latch,
    input  logic [CW-1:0] count,
    input  logic          ovf,
    input  logic [IW-1:0] idx,
    input  logic [7:0]    cmd_byte,
    output logic [AW-1:0] cmd_sel,
    output logic [IW-1:0] resp_len,
    output logic [7:0]    resp_byte
);
    logic          err_q;
    logic [31:0]   len32;
    logic [IW-1:0] body_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q    <= 1'b0;
            resp_len <= IW'(HDR_BYTES);
        end else if (latch) begin
            err_q    <= ovf;
            resp_len <= ovf ? IW'(ERR_BYTES) : IW'(HDR_BYTES) + IW'(count);
        end
    end

    assign len32    = {{(32-IW){1'b0}}, resp_len};
    assign body_idx = idx - IW'(HDR_BYTES);
    assign cmd_sel  = body_idx[AW-1:0];

    always_comb begin
        unique case (idx)
            IW'(0): resp_byte = TAG_HI;
            IW'(1): resp_byte = TAG_LO;
            IW'(2): resp_byte = len32[31:24];
            IW'(3): resp_byte = len32[23:16];
            IW'(4): resp_byte = len32[15:8];
            IW'(5): resp_byte = len32[7:0];
            default: begin
                if (err_q) begin
                    resp_byte = (idx == IW'(ERR_BYTES - 1)) ? ERR_CODE : 8'h00;
                end else begin
                    resp_byte = cmd_byte;
                end
            end
        endcase
    end
endmodule

// File: rtl/fm_ctrl.sv
module fm_ctrl
    import fm_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int IBF_LAT = 4,
    localparam int IW   = $clog2(DEPTH + HDR_BYTES + 1),
    localparam int LATW = $clog2(IBF_LAT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          addr,
    input  logic [7:0]    wdata,
    input  logic [IW-1:0] resp_len,
    input  logic [7:0]    resp_byte,
    output fm_state_e     state,
    output logic          obf,
    output logic          ibf,
    output logic          flag,
    output logic [7:0]    out_byte,
    output logic          push,
    output logic          store_clr,
    output logic          latch,
    output logic [IW-1:0] idx
);
    fm_state_e      nxt;
    logic           cmd_wr;
    logic           dat_wr;
    logic           dat_rd;
    logic           abort;
    logic           open;
    logic           presenting;
    logic [LATW-1:0] lat_cnt;

    assign cmd_wr     = wr_en && addr;
    assign dat_wr     = wr_en && !addr;
    assign dat_rd     = rd_en && !addr && obf;
    assign abort      = cmd_wr && wdata == CODE_ABORT;
    assign open       = cmd_wr && wdata == CODE_OPEN && state == ST_READY;
    assign push       = dat_wr && state == ST_RECV && !ibf;
    assign store_clr  = abort || open;
    assign latch      = state == ST_EXEC;
    assign presenting = state == ST_HEAD || state == ST_BODY || state == ST_TAIL;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_READY;
        end else begin
            state <= nxt;
        end
    end

    // next-state decode
    always_comb begin
        nxt = state;
        if (abort) begin
            nxt = ST_READY;
        end else begin
            unique case (state)
                ST_READY: if (open) nxt = ST_RECV;
                ST_RECV:  if (cmd_wr && wdata == CODE_END) nxt = ST_EXEC;
                ST_EXEC:  nxt = ST_HEAD;
                ST_HEAD:  if (dat_rd) nxt = ST_BODY;
                ST_BODY:  if (dat_rd && idx == resp_len - 1'b1) nxt = ST_TAIL;
                ST_TAIL:  if (dat_rd) nxt = ST_READY;
                default:  nxt = ST_READY;
            endcase
        end
    end

    // outputs and handshake flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            obf      <= 1'b0;
            ibf      <= 1'b0;
            flag     <= 1'b0;
            out_byte <= 8'h00;
            lat_cnt  <= '0;
            idx      <= '0;
        end else if (abort) begin
            obf     <= 1'b0;
            ibf     <= 1'b0;
            flag    <= 1'b0;
            lat_cnt <= '0;
        end else begin
            if (push) begin
                ibf     <= 1'b1;
                lat_cnt <= LATW'(IBF_LAT - 1);
            end else if (ibf) begin
                if (lat_cnt == '0) begin
                    ibf <= 1'b0;
                end else begin
                    lat_cnt <= lat_cnt - 1'b1;
                end
            end

            if (state == ST_EXEC) begin
                idx <= '0;
            end

            if (dat_rd) begin
                obf <= 1'b0;
                if (state == ST_BODY) begin
                    idx <= idx + 1'b1;
                end
            end else if (!obf && presenting) begin
                obf <= 1'b1;
                unique case (state)
                    ST_HEAD: begin
                        out_byte <= CODE_OPEN;
                        flag     <= 1'b1;
                    end
                    ST_BODY: begin
                        out_byte <= resp_byte;
                        flag     <= 1'b0;
                    end
                    default: begin
                        out_byte <= CODE_END;
                        flag     <= 1'b1;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/flagged_mailbox.sv
module flagged_mailbox
    import fm_pkg::*;
#(
    parameter int         DEPTH    = 16,
    parameter int         IBF_LAT  = 4,
    parameter logic [7:0] ERR_CODE = 8'h15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic       addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int IW = $clog2(DEPTH + HDR_BYTES + 1);

    fm_state_e     state;
    logic          obf;
    logic          ibf;
    logic          flag;
    logic [7:0]    out_byte;
    logic          push;
    logic          store_clr;
    logic          latch;
    logic [IW-1:0] idx;
    logic [IW-1:0] resp_len;
    logic [7:0]    resp_byte;
    logic [AW-1:0] cmd_sel;
    logic [7:0]    cmd_byte;
    logic [CW-1:0] count;
    logic          ovf;
    logic [7:0]    sts;

    fm_ctrl #(.DEPTH(DEPTH), .IBF_LAT(IBF_LAT)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .resp_len(resp_len), .resp_byte(resp_byte),
        .state(state), .obf(obf), .ibf(ibf), .flag(flag), .out_byte(out_byte),
        .push(push), .store_clr(store_clr), .latch(latch), .idx(idx)
    );

    fm_cmd_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(store_clr), .push(push), .din(wdata),
        .rd_sel(cmd_sel), .rd_byte(cmd_byte), .count(count), .ovf(ovf)
    );

    fm_resp_engine #(.DEPTH(DEPTH), .ERR_CODE(ERR_CODE)) u_engine (
        .clk(clk), .rst_n(rst_n), .latch(latch), .count(count), .ovf(ovf),
        .idx(idx), .cmd_byte(cmd_byte), .cmd_sel(cmd_sel),
        .resp_len(resp_len), .resp_byte(resp_byte)
    );

    // bit5 ready-for-data, bit4 ready, bit3 reserved, bit2 flag, bit1 input-full, bit0 output-full
    assign sts   = {2'b00, state == ST_RECV, state == ST_READY, 1'b0, obf && flag, ibf, obf};
    assign rdata = addr ? sts : out_byte;
endmodule

// File: rtl/fm_checker.sv
module fm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic       addr,
    input logic [7:0] wdata,
    input logic [7:0] sts
);
    logic abort_wr;
    assign abort_wr = wr_en && addr && wdata == 8'h22;

    p_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && wdata == 8'h01 && sts[4]) |=> (sts[5] && !sts[4]));

    p_ibf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && sts[5] && !sts[1]) |=> sts[1]);

    p_cancel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        abort_wr |=> (sts == 8'h10));

    p_end_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && wdata == 8'h03 && sts[5]) |=> (!sts[5] && !sts[4]));

    p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !addr && sts[0]) |=> !sts[0]);

    p_obf_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sts[0] && !(rd_en && !addr) && !abort_wr) |=> sts[0]);
endmodule

bind flagged_mailbox fm_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .sts(sts)
);

// File: tb/flagged_mailbox_bench.sv
module flagged_mailbox_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int NVEC = 5;
    // {command length, first byte, expected total reply length}
    localparam logic [7:0] VEC [NVEC][3] = '{
        '{8'd0,  8'h00, 8'd6},
        '{8'd1,  8'h5A, 8'd7},
        '{8'd5,  8'h10, 8'd11},
        '{8'd16, 8'hE0, 8'd22},
        '{8'd17, 8'h30, 8'd10}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    flagged_mailbox u_flagged_mailbox (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic a, output logic [7:0] d);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_sts(input logic [7:0] mask, input logic [7:0] val, input string tag);
        logic [7:0] s;
        bit ok = 1'b0;
        for (int k = 0; k < 200; k++) begin
            bus_rd(1'b1, s);
            if ((s & mask) == val) begin ok = 1'b1; break; end
        end
        if (!ok) begin
            n_chk++; n_bad++;
            $display("FAIL %s poll timeout actual=%02h expected=%02h", tag, s & mask, val);
        end
    endtask

    task automatic send_cmd(input int n, input logic [7:0] seed);
        bus_wr(1'b1, 8'h01);
        for (int i = 0; i < n; i++) begin
            wait_sts(8'h02, 8'h00, "R3 input-full");
            bus_wr(1'b0, seed + 8'(i));
        end
        wait_sts(8'h02, 8'h00, "R3 input-full");
        bus_wr(1'b1, 8'h03);
    endtask

    function automatic logic [7:0] exp_byte(input int n, input logic [7:0] seed,
                                            input int len, input int i);
        case (i)
            0: return 8'h00;
            1: return 8'hC4;
            2, 3, 4: return 8'h00;
            5: return 8'(len);
            default: begin
                if (n > DEPTH) return (i == 9) ? 8'h15 : 8'h00;
                return seed + 8'(i - 6);
            end
        endcase
    endfunction

    task automatic get_reply(input int n, input logic [7:0] seed, input int len);
        logic [7:0] s;
        logic [7:0] d;
        wait_sts(8'h01, 8'h01, "R6 first byte");
        bus_rd(1'b1, s); chk("R5 head status", s, 8'h05);
        bus_rd(1'b0, d); chk("R5 head byte", d, 8'h01);
        for (int i = 0; i < len; i++) begin
            wait_sts(8'h01, 8'h01, "R6 body byte");
            bus_rd(1'b1, s); chk("R5 body status", s, 8'h01);
            bus_rd(1'b0, d);
            chk(n > DEPTH ? "R8 error byte" : "R7 reply byte", d, exp_byte(n, seed, len, i));
        end
        wait_sts(8'h01, 8'h01, "R6 tail");
        bus_rd(1'b1, s); chk("R5 tail status", s, 8'h05);
        bus_rd(1'b0, d); chk("R5 tail byte", d, 8'h03);
        bus_rd(1'b1, s); chk("R9 ready after tail", s, 8'h10);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] s;
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_rd(1'b1, s); chk("R1 reset status", s, 8'h10);
        bus_rd(1'b0, d); chk("R1 reset data", d, 8'h00);

        // table of commands, issued back to back (R9)
        for (int v = 0; v < NVEC; v++) begin
            send_cmd(int'(VEC[v][0]), VEC[v][1]);
            get_reply(int'(VEC[v][0]), VEC[v][1], int'(VEC[v][2]));
        end

        // R10 stray data write when ready; R2 open; R10 open while receiving
        bus_wr(1'b0, 8'h77);
        bus_rd(1'b1, s); chk("R10 data write in ready", s, 8'h10);
        bus_wr(1'b1, 8'h01);
        bus_rd(1'b1, s); chk("R2 open sets ready-for-data", s, 8'h20);
        bus_wr(1'b1, 8'h01);
        bus_rd(1'b1, s); chk("R10 open while receiving", s, 8'h20);
        bus_wr(1'b1, 8'h03);
        get_reply(0, 8'h00, 6);

        // R3 write while input-full is dropped
        bus_wr(1'b1, 8'h01);
        bus_wr(1'b0, 8'hA1);
        bus_wr(1'b0, 8'hB2);
        bus_rd(1'b1, s); chk("R3 input-full set", s, 8'h22);
        wait_sts(8'h02, 8'h00, "R3 input-full clears");
        bus_wr(1'b1, 8'h03);
        get_reply(1, 8'hA1, 7);

        // R4 abort while receiving
        bus_wr(1'b1, 8'h01);
        bus_wr(1'b0, 8'h44);
        bus_wr(1'b1, 8'h22);
        bus_rd(1'b1, s); chk("R4 abort while receiving", s, 8'h10);

        // R4 abort in the middle of a reply; R6 read clears output-full
        send_cmd(2, 8'h60);
        wait_sts(8'h01, 8'h01, "R6 head");
        bus_rd(1'b0, d); chk("R5 head byte", d, 8'h01);
        bus_rd(1'b1, s); chk("R6 read clears output-full", s, 8'h00);
        wait_sts(8'h01, 8'h01, "R6 next byte");
        bus_wr(1'b1, 8'h22);
        bus_rd(1'b1, s); chk("R4 abort in reply", s, 8'h10);

        // fresh command after abort leaves no residue
        send_cmd(1, 8'h9C);
        get_reply(1, 8'h9C, 7);

        finish_run();
    end
endmodule